// File: doc/BRIEF.md
# CAN Receive Message Queue with Acceptance Filtering

This block sits behind a CAN protocol engine. The engine presents each fully received message for one cycle, with a valid strobe. The message carries a 29-bit identifier, eight data bytes, a remote flag, an extended flag and a 4-bit length. The block compares the message against up to three programmable mask/code filters. A filter spans the identifier and the first two data bytes.

Each accepted message is written into a four-entry first-in first-out queue. The entry is tagged with the index of the filter that let it through. Software reads the oldest entry from the head outputs and removes it with a one-cycle pop strobe. The block reports the fill count and a message-available flag. A sticky receive interrupt rises when the fill count reaches a programmable threshold. A separate sticky overrun flag records messages that were lost. When the queue is full, a configuration input picks the policy: drop the new message, or replace the newest stored entry.

Top module: `canRxFilterFifo`

## Requirements
- R1: After reset the fill count is 0, the message-available flag is 0, and both interrupt flags are 0.
- R2: The filter key is 45 bits wide. Key bits 44..16 are the identifier bits 28..0. Key bits 15..0 are message data bits 63..48, which are the first two data bytes. Filter i uses bits [i*45 +: 45] of the mask and code inputs. A mask bit of 1 makes the key bit take part in the comparison against the code bit. A mask bit of 0 makes that key bit a don't-care. Data bits 47..0 never affect acceptance.
- R3: When all filter enables are 0, every message is accepted and tagged with index 0.
- R4: When at least one filter is enabled, a message is accepted only if an enabled filter matches it. The tag is the lowest index among the enabled filters that match. A message that matches no enabled filter leaves the queue unchanged.
- R5: Entries leave the queue in arrival order. The head outputs show the identifier, data, remote flag, extended flag, length and tag of the oldest entry. A pop removes that entry.
- R6: The fill count (0 to 4) and the message-available flag follow each push and each pop in the same clock edge. The message-available flag is 1 exactly when the fill count is not 0.
- R7: If the queue is full, overwrite is off and no pop happens, an accepted message is discarded and the overrun flag is set. The overrun flag stays 1 until a cycle with the overrun-clear strobe.
- R8: If the queue is full, overwrite is on and no pop happens, an accepted message replaces the newest entry. The count stays 4, the three older entries are kept, and the overrun flag does not change.
- R9: With level field L (0 to 3), the receive interrupt flag is set at the edge after the fill count reaches L+1 or more. A receive-clear strobe clears the flag only when the fill count is at most L.
- R10: A pop while the queue is empty has no effect.
- R11: A push and a pop on the same edge remove the oldest entry and append the new one, even when the queue is full. The count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msgValid | input | 1 | One-cycle strobe: a received message is present |
| msgId | input | 29 | Received identifier |
| msgData | input | 64 | Received data, first byte in bits 63..56 |
| msgRtr | input | 1 | Received remote flag |
| msgIde | input | 1 | Received extended-format flag |
| msgDlc | input | 4 | Received length code |
| filtMask | input | 135 | Three 45-bit masks, filter i at [i*45 +: 45] |
| filtCode | input | 135 | Three 45-bit codes, same layout |
| filtEn | input | 3 | Per-filter enable |
| overwriteEn | input | 1 | Full-queue policy: 1 replaces the newest entry, 0 drops |
| rxLevel | input | 2 | Receive interrupt threshold, count >= value+1 |
| pop | input | 1 | Remove the head entry |
| rxIrqClr | input | 1 | Clear the receive interrupt flag |
| ovrIrqClr | input | 1 | Clear the overrun flag |
| headId | output | 29 | Head entry identifier |
| headData | output | 64 | Head entry data |
| headRtr | output | 1 | Head entry remote flag |
| headIde | output | 1 | Head entry extended flag |
| headDlc | output | 4 | Head entry length |
| headTag | output | 3 | Index of the filter that accepted the head entry |
| fillCount | output | 3 | Number of stored entries |
| msgAvail | output | 1 | At least one entry stored |
| rxIrq | output | 1 | Sticky receive threshold interrupt |
| ovrIrq | output | 1 | Sticky overrun interrupt |

## Verification
The in-RTL properties check the following on every cycle:
- the fill count never goes above four;
- a drop at a full queue raises the overrun flag;
- an overwrite keeps the count and the read position unchanged;
- an empty pop changes nothing;
- a count above the threshold forces the receive flag;
- every reported tag names an enabled filter, or is 0 when no filter is enabled.

Some behaviour can only be shown by the directed scenarios. These are the data that come out of the queue, that is, arrival order, which entry is replaced on overwrite, and which message is lost on a drop. They also cover the don't-care behaviour of mask bits and the rule that the lowest matching filter wins.

// File: rtl/canRxPkg.sv
package canRxPkg;
  localparam int ID_W       = 29;
  localparam int DATA_W     = 64;
  localparam int KEY_DATA_W = 16;
  localparam int KEY_W      = ID_W + KEY_DATA_W;
  localparam int DLC_W      = 4;
  localparam int TAG_W      = 3;
  localparam int FIFO_DEPTH = 4;
  localparam int PTR_W      = $clog2(FIFO_DEPTH);
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [DATA_W-1:0] data;
    logic              rtr;
    logic              ide;
    logic [DLC_W-1:0]  dlc;
    logic [TAG_W-1:0]  tag;
  } rxEntryT;

  typedef struct packed {
    logic             wrEn;
    logic [PTR_W-1:0] wrIdx;
    logic [PTR_W-1:0] rdIdx;
  } storeCtlT;
endpackage

// File: rtl/canRxMatch.sv
module canRxMatch
  import canRxPkg::*;
#(
  parameter int NUM_FILT = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [KEY_W-1:0]          key,
  input  logic [NUM_FILT*KEY_W-1:0] mask,
  input  logic [NUM_FILT*KEY_W-1:0] code,
  input  logic [NUM_FILT-1:0]       en,
  output logic                      accept,
  output logic [TAG_W-1:0]          tag
);
  logic [NUM_FILT-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NUM_FILT; g++) begin : gFilt
      assign hit[g] = en[g] &&
        (((key ^ code[g*KEY_W +: KEY_W]) & mask[g*KEY_W +: KEY_W]) == '0);
    end
  endgenerate

  logic found;
  always_comb begin
    found = 1'b0;
    tag   = '0;
    for (int i = 0; i < NUM_FILT; i++) begin
      if (hit[i] && !found) begin
        found = 1'b1;
        tag   = TAG_W'(i);
      end
    end
    accept = (en == '0) || found;
  end

  // R3
  none_enabled_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (en == '0) |-> (accept && tag == '0));
  // R4
  tag_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && en != '0) |-> (((en >> tag) & NUM_FILT'(1)) != '0));
endmodule

// File: rtl/canRxCtl.sv
module canRxCtl
  import canRxPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic             overwriteEn,
  input  logic [1:0]       rxLevel,
  input  logic             rxIrqClr,
  input  logic             ovrIrqClr,
  output storeCtlT         ctl,
  output logic [CNT_W-1:0] count,
  output logic             msgAvail,
  output logic             rxIrq,
  output logic             ovrIrq
);
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic full, empty, doPop, normalPush, ovrWrite, dropMsg, levelMet;

  function automatic logic [PTR_W-1:0] incPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction
  function automatic logic [PTR_W-1:0] decPtr(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(FIFO_DEPTH - 1) : p - 1'b1;
  endfunction

  always_comb begin
    full       = (count == CNT_W'(FIFO_DEPTH));
    empty      = (count == '0);
    doPop      = pop && !empty;
    normalPush = push && (!full || doPop);
    ovrWrite   = push && full && !doPop && overwriteEn;
    dropMsg    = push && full && !doPop && !overwriteEn;
    levelMet   = (count > CNT_W'(rxLevel));
    ctl.wrEn   = normalPush || ovrWrite;
    ctl.wrIdx  = ovrWrite ? decPtr(wrPtr) : wrPtr;
    ctl.rdIdx  = rdPtr;
    msgAvail   = !empty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      rxIrq  <= 1'b0;
      ovrIrq <= 1'b0;
    end else begin
      if (normalPush) wrPtr <= incPtr(wrPtr);
      if (doPop)      rdPtr <= incPtr(rdPtr);
      count  <= count + CNT_W'(normalPush) - CNT_W'(doPop);
      rxIrq  <= (rxIrq && !rxIrqClr) || levelMet;
      ovrIrq <= (ovrIrq && !ovrIrqClr) || dropMsg;
    end
  end

  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(FIFO_DEPTH));
  // R7
  drop_sets_ovr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && count == CNT_W'(FIFO_DEPTH) && !pop && !overwriteEn)
      |=> (ovrIrq && count == CNT_W'(FIFO_DEPTH)));
  // R8
  ovr_keeps_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && count == CNT_W'(FIFO_DEPTH) && !pop && overwriteEn)
      |=> (count == CNT_W'(FIFO_DEPTH) && $stable(rdPtr)));
  // R9
  level_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count > CNT_W'(rxLevel)) |=> rxIrq);
  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0 && pop && !push) |=> (count == '0 && $stable(rdPtr)));
endmodule

// File: rtl/canRxStore.sv
module canRxStore
  import canRxPkg::*;
(
  input  logic     clk,
  input  storeCtlT ctl,
  input  rxEntryT  wrEntry,
  output rxEntryT  headEntry
);
  rxEntryT mem [FIFO_DEPTH];

  always_ff @(posedge clk) begin
    if (ctl.wrEn) mem[ctl.wrIdx] <= wrEntry;
  end

  assign headEntry = mem[ctl.rdIdx];
endmodule

// File: rtl/canRxFilterFifo.sv
module canRxFilterFifo
  import canRxPkg::*;
#(
  parameter int NUM_FILT = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      msgValid,
  input  logic [ID_W-1:0]           msgId,
  input  logic [DATA_W-1:0]         msgData,
  input  logic                      msgRtr,
  input  logic                      msgIde,
  input  logic [DLC_W-1:0]          msgDlc,
  input  logic [NUM_FILT*KEY_W-1:0] filtMask,
  input  logic [NUM_FILT*KEY_W-1:0] filtCode,
  input  logic [NUM_FILT-1:0]       filtEn,
  input  logic                      overwriteEn,
  input  logic [1:0]                rxLevel,
  input  logic                      pop,
  input  logic                      rxIrqClr,
  input  logic                      ovrIrqClr,
  output logic [ID_W-1:0]           headId,
  output logic [DATA_W-1:0]         headData,
  output logic                      headRtr,
  output logic                      headIde,
  output logic [DLC_W-1:0]          headDlc,
  output logic [TAG_W-1:0]          headTag,
  output logic [CNT_W-1:0]          fillCount,
  output logic                      msgAvail,
  output logic                      rxIrq,
  output logic                      ovrIrq
);
  logic             accept;
  logic [TAG_W-1:0] matchTag;
  storeCtlT         ctl;
  rxEntryT          wrEntry, headEntry;

  canRxMatch #(.NUM_FILT(NUM_FILT)) uMatch (
    .clk(clk), .rstN(rstN),
    .key({msgId, msgData[DATA_W-1 -: KEY_DATA_W]}),
    .mask(filtMask), .code(filtCode), .en(filtEn),
    .accept(accept), .tag(matchTag)
  );

  canRxCtl uCtl (
    .clk(clk), .rstN(rstN), .push(msgValid && accept), .pop(pop),
    .overwriteEn(overwriteEn), .rxLevel(rxLevel),
    .rxIrqClr(rxIrqClr), .ovrIrqClr(ovrIrqClr),
    .ctl(ctl), .count(fillCount), .msgAvail(msgAvail),
    .rxIrq(rxIrq), .ovrIrq(ovrIrq)
  );

  assign wrEntry = '{id: msgId, data: msgData, rtr: msgRtr, ide: msgIde,
                     dlc: msgDlc, tag: matchTag};

  canRxStore uStore (.clk(clk), .ctl(ctl), .wrEntry(wrEntry), .headEntry(headEntry));

  assign headId   = headEntry.id;
  assign headData = headEntry.data;
  assign headRtr  = headEntry.rtr;
  assign headIde  = headEntry.ide;
  assign headDlc  = headEntry.dlc;
  assign headTag  = headEntry.tag;
endmodule

// File: tb/canRxFilterFifo_test.sv
module canRxFilterFifo_test;
  localparam int KW = 45;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msgValid = 1'b0;
  logic [28:0] msgId = '0;
  logic [63:0] msgData = '0;
  logic msgRtr = 1'b0, msgIde = 1'b0;
  logic [3:0] msgDlc = '0;
  logic [3*KW-1:0] filtMask = '0, filtCode = '0;
  logic [2:0] filtEn = '0;
  logic overwriteEn = 1'b0;
  logic [1:0] rxLevel = 2'd3;
  logic pop = 1'b0, rxIrqClr = 1'b0, ovrIrqClr = 1'b0;
  logic [28:0] headId;
  logic [63:0] headData;
  logic headRtr, headIde;
  logic [3:0] headDlc;
  logic [2:0] headTag;
  logic [2:0] fillCount;
  logic msgAvail, rxIrq, ovrIrq;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  canRxFilterFifo uut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [28:0] id, input logic [63:0] d,
                      input logic r = 1'b0, input logic e = 1'b0,
                      input logic [3:0] l = 4'd8, input logic alsoPop = 1'b0);
    msgValid = 1'b1; msgId = id; msgData = d; msgRtr = r; msgIde = e; msgDlc = l;
    pop = alsoPop;
    @(posedge clk); @(negedge clk);
    msgValid = 1'b0; pop = 1'b0;
  endtask

  task automatic popOne();
    pop = 1'b1;
    @(posedge clk); @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic expectHead(input string req, input logic [28:0] id);
    chk(req, 64'(headId), 64'(id));
    popOne();
  endtask

  task automatic setFilter(input int i, input logic [KW-1:0] m, input logic [KW-1:0] c);
    filtMask[i*KW +: KW] = m;
    filtCode[i*KW +: KW] = c;
  endtask

  task automatic tReset();
    chk("R1 fill", 64'(fillCount), 0);
    chk("R1 avail", 64'(msgAvail), 0);
    chk("R1 rxIrq", 64'(rxIrq), 0);
    chk("R1 ovrIrq", 64'(ovrIrq), 0);
  endtask

  task automatic tPassAll();
    filtEn = 3'b000;
    setFilter(0, '1, '0);
    send(29'h1ABCDEF0, 64'h0102030405060708);
    chk("R3 fill", 64'(fillCount), 1);
    chk("R6 avail", 64'(msgAvail), 1);
    chk("R3 tag", 64'(headTag), 0);
    chk("R5 data", headData, 64'h0102030405060708);
    popOne();
    chk("R6 fill after pop", 64'(fillCount), 0);
    chk("R6 avail after pop", 64'(msgAvail), 0);
  endtask

  task automatic tFilters();
    setFilter(0, '1, {29'h123, 16'hBEEF});
    setFilter(1, {{29{1'b1}}, 16'h0}, {29'h123, 16'h0});
    setFilter(2, '0, '1);
    filtEn = 3'b110;
    send(29'h123, 64'h1234_0000_0000_0000);
    chk("R4 disabled filter skipped tag", 64'(headTag), 1);
    popOne();
    send(29'h555, 64'h0);
    chk("R4 fallthrough tag", 64'(headTag), 2);
    popOne();
    filtEn = 3'b001;
    send(29'h123, 64'hBEEF_0000_0000_0000);
    send(29'h123, 64'hBEEF_FFFF_FFFF_FFFF);
    chk("R2 low data is dont-care", 64'(fillCount), 2);
    send(29'h123, 64'hBEEE_0000_0000_0000);
    chk("R4 reject data mismatch", 64'(fillCount), 2);
    send(29'h122, 64'hBEEF_0000_0000_0000);
    chk("R2 reject id mismatch", 64'(fillCount), 2);
    popOne(); popOne();
    filtEn = 3'b011;
    send(29'h123, 64'hBEEF_0000_0000_0000);
    chk("R4 lowest wins", 64'(headTag), 0);
    popOne();
    setFilter(1, {29'h0, 16'hFF00}, {29'h0, 16'h4200});
    filtEn = 3'b010;
    send(29'h7777, 64'h42AB_0000_0000_0000);
    chk("R2 masked data byte", 64'(fillCount), 1);
    popOne();
    filtEn = 3'b000;
  endtask

  task automatic tOrder();
    send(29'h11, 64'hA, 1'b1, 1'b0, 4'd1);
    send(29'h22, 64'hB, 1'b0, 1'b1, 4'd2);
    send(29'h33, 64'hC, 1'b1, 1'b1, 4'd7);
    chk("R5 id0", 64'(headId), 64'h11);
    chk("R5 rtr0", 64'(headRtr), 1);
    chk("R5 ide0", 64'(headIde), 0);
    chk("R5 dlc0", 64'(headDlc), 1);
    popOne();
    chk("R5 id1", 64'(headId), 64'h22);
    chk("R5 ide1", 64'(headIde), 1);
    chk("R5 dlc1", 64'(headDlc), 2);
    popOne();
    chk("R5 id2", 64'(headId), 64'h33);
    chk("R5 dlc2", 64'(headDlc), 7);
    popOne();
  endtask

  task automatic tLevel();
    rxLevel = 2'd2;
    send(29'h1, 0); send(29'h2, 0); idle();
    chk("R9 below threshold", 64'(rxIrq), 0);
    send(29'h3, 0);
    chk("R9 not yet", 64'(rxIrq), 0);
    idle();
    chk("R9 set", 64'(rxIrq), 1);
    rxIrqClr = 1'b1; idle(); rxIrqClr = 1'b0;
    chk("R9 clear ignored at level", 64'(rxIrq), 1);
    popOne();
    rxIrqClr = 1'b1; idle(); rxIrqClr = 1'b0;
    chk("R9 clear below level", 64'(rxIrq), 0);
    popOne(); popOne();
    rxLevel = 2'd0;
    send(29'h9, 0); idle();
    chk("R9 level0", 64'(rxIrq), 1);
    popOne();
    rxIrqClr = 1'b1; idle(); rxIrqClr = 1'b0;
    rxLevel = 2'd3;
  endtask

  task automatic tDrop();
    overwriteEn = 1'b0;
    for (int k = 1; k <= 4; k++) send(29'(k), 0);
    chk("R6 full", 64'(fillCount), 4);
    chk("R7 no ovr yet", 64'(ovrIrq), 0);
    send(29'h99, 0);
    chk("R7 count after drop", 64'(fillCount), 4);
    chk("R7 ovr set", 64'(ovrIrq), 1);
    for (int k = 1; k <= 4; k++) expectHead("R7 order", 29'(k));
    chk("R7 dropped msg absent", 64'(fillCount), 0);
    chk("R7 ovr sticky", 64'(ovrIrq), 1);
    ovrIrqClr = 1'b1; idle(); ovrIrqClr = 1'b0;
    chk("R7 ovr cleared", 64'(ovrIrq), 0);
  endtask

  task automatic tOverwrite();
    overwriteEn = 1'b1;
    for (int k = 1; k <= 4; k++) send(29'(k + 16), 0);
    send(29'h55, 0);
    chk("R8 count", 64'(fillCount), 4);
    chk("R8 no ovr", 64'(ovrIrq), 0);
    expectHead("R8 e0", 29'h11);
    expectHead("R8 e1", 29'h12);
    expectHead("R8 e2", 29'h13);
    expectHead("R8 newest replaced", 29'h55);
    overwriteEn = 1'b0;
  endtask

  task automatic tEmptyPop();
    popOne();
    chk("R10 fill", 64'(fillCount), 0);
    chk("R10 avail", 64'(msgAvail), 0);
    send(29'h77, 0);
    chk("R10 fill after push", 64'(fillCount), 1);
    expectHead("R10 head", 29'h77);
  endtask

  task automatic tPushPop();
    send(29'h40, 0);
    send(29'h41, 0, 1'b0, 1'b0, 4'd8, 1'b1);
    chk("R11 count one", 64'(fillCount), 1);
    chk("R11 head one", 64'(headId), 64'h41);
    send(29'h42, 0); send(29'h43, 0); send(29'h44, 0);
    send(29'h45, 0, 1'b0, 1'b0, 4'd8, 1'b1);
    chk("R11 count full", 64'(fillCount), 4);
    chk("R11 no ovr", 64'(ovrIrq), 0);
    for (int k = 2; k <= 5; k++) expectHead("R11 order", 29'(64 + k));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle();
    tReset();
    tPassAll();
    tFilters();
    tOrder();
    tLevel();
    tDrop();
    tOverwrite();
    tEmptyPop();
    tPushPop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule